// File: doc/BRIEF.md
# Split Timestamp Timer with Period and Overflow Compares

This block keeps a 40-bit time base for scheduling radio activity. The low part is a 16-bit counter that runs from zero up to a programmable period and then starts again. Each time it starts again, a 24-bit overflow counter advances by one. The overflow counter therefore counts whole periods, and the low counter gives the position inside the current period.

Two external events, a frame-delimiter strobe and an end-of-transmission strobe, copy the full 40-bit time into a capture register. Both halves of the copy come from the same cycle. Two compares watch the low counter and two watch the overflow counter. Each compare emits a one-cycle event pulse and sets a sticky flag, so the pulses can start a receive or transmit operation or raise a general interrupt.

Software reaches the block through a byte-wide register port. Reading the lowest counter byte freezes the upper counter bytes in a shadow copy, so a multi-byte read returns one consistent value.

Top module: `tstamp_timer`

## Requirements
- R1: After reset the following all read zero: control (0x00, bit0 = run, bit1 = clear strobe), flags (0x01), counter bytes (0x04 to 0x08) and capture bytes (0x09 to 0x0D), and all event outputs are low. The period register (0x02 low byte, 0x03 high byte) resets to 0xFFFF.
- R2: While run is 1, the low counter steps up by one each cycle until it reaches or passes the period, and on the next step it returns to 0. Counter byte 0x04 is bits 7:0 and byte 0x05 is bits 15:8.
- R3: The overflow counter advances by one in exactly the cycles in which the low counter returns to 0, and holds otherwise. Its bytes are 0x06 (bits 7:0), 0x07 and 0x08. With a period of 0 it advances on every running cycle.
- R4: While run is 0, both counters hold their values. Writing 0x00 with bit1 set zeroes both counters on the next edge, whatever the run state.
- R5: A cycle in which the frame-delimiter or end-of-transmission input is high stores that cycle's {overflow, low} value in the capture register. The low counter goes to 0x09 and 0x0A, the overflow counter to 0x0B to 0x0D. Without such an input the capture register holds.
- R6: Low compare k (registers 0x0E/0x0F for k=0 and 0x10/0x11 for k=1, little-endian) drives event bit k high for one cycle. That cycle is the one in which a running count has just stepped onto the compare value. A stopped counter gives no pulse.
- R7: Overflow compare k (0x12 to 0x14 for k=0, 0x15 to 0x17 for k=1) pulses event bit 2+k in the cycle in which the overflow counter has just stepped onto its compare value.
- R8: Flag bits 3:0 of 0x01 follow the event bit order. Each flag sets together with its pulse and stays set until a 1 is written to that bit. Writing 0 has no effect.
- R9: A read of 0x04 returns the live low byte and copies counter bits 39:8 into a shadow. Reads of 0x05 to 0x08 return the shadow, not the live count.
- R10: The period and compare registers read back the bytes written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_rd | input | 1 | Read strobe; used to latch the counter shadow |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sof_i | input | 1 | Frame-delimiter capture strobe |
| eot_i | input | 1 | End-of-transmission capture strobe |
| evt_o | output | 4 | Compare pulses: bits 1:0 low compares, bits 3:2 overflow compares |

## Verification
A low counter that takes a wrong step becomes visible at the next read of 0x04. It also shows up one period later as an overflow count that is off, or as a compare pulse that is missing or extra on evt_o. A carry placed in the wrong cycle or an overflow counter that is off by one is seen as soon as the bytes 0x06 to 0x08 or the overflow compare pulses are checked. Capture or shadow state taken from the wrong cycle shows as values that disagree with the tick count the bench drives, on the first read after the strobe.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int REG_DW       = 8;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int A_CTRL       = 0;
  localparam int A_FLAG       = 1;
  localparam int A_PER        = 2;
  localparam int N_LCMP       = 2;
  localparam int N_HCMP       = 2;
  localparam int N_EVT        = N_LCMP + N_HCMP;
endpackage

// File: rtl/tst_counter.sv
module tst_counter #(
  parameter int LO_W = 16,
  parameter int HI_W = 24
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            run,
  input  logic            clr,
  input  logic [LO_W-1:0] period,
  output logic [LO_W-1:0] lo,
  output logic [HI_W-1:0] hi,
  output logic            tick,
  output logic            wrap,
  output logic [LO_W-1:0] lo_nxt,
  output logic [HI_W-1:0] hi_nxt
);
  always_comb begin
    tick   = run && !clr;
    wrap   = (lo >= period);
    lo_nxt = wrap ? '0 : lo + 1'b1;
    hi_nxt = wrap ? hi + 1'b1 : hi;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lo <= '0;
      hi <= '0;
    end else if (clr) begin
      lo <= '0;
      hi <= '0;
    end else if (tick) begin
      lo <= lo_nxt;
      hi <= hi_nxt;
    end
  end
endmodule

// File: rtl/tst_compare.sv
module tst_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         en,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] ref_val,
  output logic         hit,
  output logic         evt
);
  always_comb hit = en && (nxt == ref_val);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) evt <= 1'b0;
    else         evt <= hit;
  end
endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer
  import tstamp_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 24,
  parameter int AW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              sof_i,
  input  logic              eot_i,
  output logic [N_EVT-1:0]  evt_o
);
  localparam int TW     = LO_W + HI_W;
  localparam int LO_B   = LO_W / REG_DW;
  localparam int HI_B   = HI_W / REG_DW;
  localparam int TB     = TW / REG_DW;
  localparam int A_CNT  = A_PER + LO_B;
  localparam int A_CAP  = A_CNT + TB;
  localparam int A_LCMP = A_CAP + TB;
  localparam int A_HCMP = A_LCMP + N_LCMP * LO_B;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic                         run_q, run_d, clr;
  logic [LO_W-1:0]              period_q, period_d;
  logic [N_LCMP-1:0][LO_W-1:0]  lcmp_q, lcmp_d;
  logic [N_HCMP-1:0][HI_W-1:0]  hcmp_q, hcmp_d;
  logic [N_EVT-1:0]             flag_q, flag_d, hit, w1c;
  logic [TW-1:0]                cap_q, cap_d, now_w;
  logic [TW-REG_DW-1:0]         shd_q, shd_d;
  logic [LO_W-1:0]              cnt_lo, lo_nxt;
  logic [HI_W-1:0]              cnt_hi, hi_nxt;
  logic                         tick, wrap;

  tst_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .run(run_q), .clr(clr), .period(period_q),
    .lo(cnt_lo), .hi(cnt_hi), .tick(tick), .wrap(wrap),
    .lo_nxt(lo_nxt), .hi_nxt(hi_nxt)
  );

  for (genvar k = 0; k < N_LCMP; k++) begin : g_lcmp
    tst_compare #(.W(LO_W)) u_cmp (
      .clk(clk), .rst_ni(rst_ni), .en(tick), .nxt(lo_nxt),
      .ref_val(lcmp_q[k]), .hit(hit[k]), .evt(evt_o[k])
    );
  end

  for (genvar k = 0; k < N_HCMP; k++) begin : g_hcmp
    tst_compare #(.W(HI_W)) u_cmp (
      .clk(clk), .rst_ni(rst_ni), .en(tick && wrap), .nxt(hi_nxt),
      .ref_val(hcmp_q[k]), .hit(hit[N_LCMP+k]), .evt(evt_o[N_LCMP+k])
    );
  end

  assign now_w = {cnt_hi, cnt_lo};

  // next-state: register writes, flags, capture, shadow
  always_comb begin
    run_d    = run_q;
    clr      = 1'b0;
    period_d = period_q;
    lcmp_d   = lcmp_q;
    hcmp_d   = hcmp_q;
    w1c      = '0;
    if (reg_wr) begin
      if (reg_addr == AW'(A_CTRL)) begin
        run_d = reg_wdata[CTRL_RUN_BIT];
        clr   = reg_wdata[CTRL_CLR_BIT];
      end
      if (reg_addr == AW'(A_FLAG)) w1c = reg_wdata[N_EVT-1:0];
      for (int i = 0; i < LO_B; i++) begin
        if (reg_addr == AW'(A_PER + i)) period_d[REG_DW*i +: REG_DW] = reg_wdata;
        for (int k = 0; k < N_LCMP; k++)
          if (reg_addr == AW'(A_LCMP + k*LO_B + i)) lcmp_d[k][REG_DW*i +: REG_DW] = reg_wdata;
      end
      for (int i = 0; i < HI_B; i++)
        for (int k = 0; k < N_HCMP; k++)
          if (reg_addr == AW'(A_HCMP + k*HI_B + i)) hcmp_d[k][REG_DW*i +: REG_DW] = reg_wdata;
    end
    flag_d = (flag_q & ~w1c) | hit;
    cap_d  = (sof_i || eot_i) ? now_w : cap_q;
    shd_d  = (reg_rd && reg_addr == AW'(A_CNT)) ? now_w[TW-1:REG_DW] : shd_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      period_q <= '1;
      lcmp_q   <= '0;
      hcmp_q   <= '0;
      flag_q   <= '0;
      cap_q    <= '0;
      shd_q    <= '0;
    end else begin
      run_q    <= run_d;
      period_q <= period_d;
      lcmp_q   <= lcmp_d;
      hcmp_q   <= hcmp_d;
      flag_q   <= flag_d;
      cap_q    <= cap_d;
      shd_q    <= shd_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CTRL)) reg_rdata[CTRL_RUN_BIT] = run_q;
    if (reg_addr == AW'(A_FLAG)) reg_rdata[N_EVT-1:0] = flag_q;
    for (int i = 0; i < LO_B; i++) begin
      if (reg_addr == AW'(A_PER + i)) reg_rdata = period_q[REG_DW*i +: REG_DW];
      for (int k = 0; k < N_LCMP; k++)
        if (reg_addr == AW'(A_LCMP + k*LO_B + i)) reg_rdata = lcmp_q[k][REG_DW*i +: REG_DW];
    end
    for (int i = 0; i < HI_B; i++)
      for (int k = 0; k < N_HCMP; k++)
        if (reg_addr == AW'(A_HCMP + k*HI_B + i)) reg_rdata = hcmp_q[k][REG_DW*i +: REG_DW];
    for (int i = 0; i < TB; i++) begin
      if (reg_addr == AW'(A_CAP + i)) reg_rdata = cap_q[REG_DW*i +: REG_DW];
      if (reg_addr == AW'(A_CNT + i))
        reg_rdata = (i == 0) ? now_w[REG_DW-1:0] : shd_q[REG_DW*(i-1) +: REG_DW];
    end
  end
endmodule

// File: rtl/tstamp_timer_chk.sv
module tstamp_timer_chk #(
  parameter int LO_W = 16,
  parameter int HI_W = 24
) (
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 run,
  input logic                 clr,
  input logic [LO_W-1:0]      period,
  input logic [LO_W-1:0]      lo,
  input logic [HI_W-1:0]      hi,
  input logic                 sof,
  input logic                 eot,
  input logic [LO_W+HI_W-1:0] cap,
  input logic [LO_W-1:0]      lcmp0,
  input logic [HI_W-1:0]      hcmp0,
  input logic [3:0]           evt
);
  // R2
  lo_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !clr && lo < period) |=> (lo == LO_W'($past(lo) + 1'b1)));
  // R2
  lo_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !clr && lo >= period) |=> (lo == '0));
  // R3
  hi_carry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !clr && lo >= period) |=> (hi == HI_W'($past(hi) + 1'b1)));
  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr && lo < period) |=> $stable(hi));
  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run && !clr) |=> ($stable(lo) && $stable(hi)));
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (lo == '0 && hi == '0));
  // R5
  cap_take_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (sof || eot) |=> (cap == $past({hi, lo})));
  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(sof || eot) |=> $stable(cap));
  // R6
  lo_evt_val_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(evt[0]) |-> (lo == $past(lcmp0)));
  // R6
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run || clr) |=> (evt == '0));
  // R7
  hi_evt_val_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    evt[2] |-> (hi == $past(hcmp0) && lo == '0));
endmodule

bind tstamp_timer tstamp_timer_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .run(run_q), .clr(clr), .period(period_q),
  .lo(cnt_lo), .hi(cnt_hi), .sof(sof_i), .eot(eot_i), .cap(cap_q),
  .lcmp0(lcmp_q[0]), .hcmp0(hcmp_q[0]), .evt(evt_o)
);

// File: tb/tstamp_timer_tb_top.sv
module tstamp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sof_i = 1'b0, eot_i = 1'b0;
  logic [3:0] evt_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  int ev_cnt [4] = '{default: 0};
  int snap [4];
  logic [7:0] d;

  always #2 clk = ~clk;

  tstamp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof_i(sof_i), .eot_i(eot_i), .evt_o(evt_o)
  );

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 4; k++) if (evt_o[k] === 1'b1) ev_cnt[k]++;
  end

  // {wr, addr, data, expected}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 5'h00, 8'h00, 8'h00}, {1'b0, 5'h01, 8'h00, 8'h00},
    {1'b0, 5'h02, 8'h00, 8'hFF}, {1'b0, 5'h03, 8'h00, 8'hFF},
    {1'b0, 5'h04, 8'h00, 8'h00}, {1'b0, 5'h08, 8'h00, 8'h00},
    {1'b0, 5'h09, 8'h00, 8'h00}, {1'b1, 5'h0E, 8'h5A, 8'h00},
    {1'b0, 5'h0E, 8'h00, 8'h5A}, {1'b1, 5'h17, 8'hC3, 8'h00},
    {1'b0, 5'h17, 8'h00, 8'hC3}, {1'b0, 5'h12, 8'h00, 8'h00},
    {1'b1, 5'h11, 8'hA5, 8'h00}, {1'b0, 5'h11, 8'h00, 8'hA5}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // called at a falling edge, returns at the next one
  task automatic wr(input logic [4:0] a, input logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);  // exactly n counting steps
    wr(5'h00, 8'h01);
    idle(n - 1);
    wr(5'h00, 8'h00);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc > 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    chk("R1 evt_o", evt_o, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][20:16], d);
        chk($sformatf("R1/R10 vec%0d", i), d, VEC[i][7:0]);
      end
    end

    // counting with period 4: 13 steps -> low 3, overflow 2
    wr(5'h02, 8'h04); wr(5'h03, 8'h00);
    wr(5'h00, 8'h02);
    ticks(13);
    rd(5'h04, d); chk("R2 low after 13", d, 3);
    rd(5'h05, d); chk("R2 low hi byte", d, 0);
    rd(5'h06, d); chk("R3 ovf after 13", d, 2);
    rd(5'h07, d); chk("R3 ovf byte1", d, 0);
    idle(10);
    rd(5'h04, d); chk("R4 hold low", d, 3);
    rd(5'h06, d); chk("R4 hold ovf", d, 2);

    // clear while running
    wr(5'h00, 8'h01); idle(3); wr(5'h00, 8'h02);
    rd(5'h04, d); chk("R4 clear low", d, 0);
    rd(5'h06, d); chk("R4 clear ovf", d, 0);

    // capture on frame delimiter after 6 steps: low 1, ovf 1
    wr(5'h00, 8'h01); idle(6);
    sof_i = 1'b1; @(negedge clk); sof_i = 1'b0;
    wr(5'h00, 8'h00);
    rd(5'h09, d); chk("R5 sof cap low", d, 1);
    rd(5'h0A, d); chk("R5 sof cap low hi", d, 0);
    rd(5'h0B, d); chk("R5 sof cap ovf", d, 1);

    // capture on end of transmission after 2 steps
    wr(5'h00, 8'h02);
    wr(5'h00, 8'h01); idle(2);
    eot_i = 1'b1; @(negedge clk); eot_i = 1'b0;
    wr(5'h00, 8'h00);
    rd(5'h09, d); chk("R5 eot cap low", d, 2);
    rd(5'h0B, d); chk("R5 eot cap ovf", d, 0);
    ticks(5);
    rd(5'h09, d); chk("R5 cap holds", d, 2);

    // compares: low0=2, low1=7 (unreached), ovf0=2, ovf1=5 (unreached)
    wr(5'h0E, 8'h02); wr(5'h0F, 8'h00);
    wr(5'h10, 8'h07); wr(5'h11, 8'h00);
    wr(5'h12, 8'h02); wr(5'h13, 8'h00); wr(5'h14, 8'h00);
    wr(5'h15, 8'h05); wr(5'h16, 8'h00); wr(5'h17, 8'h00);
    wr(5'h00, 8'h02);
    wr(5'h01, 8'h0F);
    for (int k = 0; k < 4; k++) snap[k] = ev_cnt[k];
    ticks(12);
    idle(2);
    chk("R6 low0 pulses", ev_cnt[0] - snap[0], 3);
    chk("R6 low1 pulses", ev_cnt[1] - snap[1], 0);
    chk("R7 ovf0 pulses", ev_cnt[2] - snap[2], 1);
    chk("R7 ovf1 pulses", ev_cnt[3] - snap[3], 0);
    rd(5'h01, d); chk("R8 flags set", d, 8'h05);
    idle(5);
    chk("R6 stopped no pulse", ev_cnt[0] - snap[0], 3);
    wr(5'h01, 8'h01);
    rd(5'h01, d); chk("R8 w1c", d, 8'h04);
    wr(5'h01, 8'h00);
    rd(5'h01, d); chk("R8 write 0 ignored", d, 8'h04);

    // shadow: read byte 0 after 8 steps, read ovf byte after 8 more
    wr(5'h00, 8'h02);
    wr(5'h00, 8'h01); idle(8);
    rd(5'h04, d); chk("R9 live low", d, 3);
    idle(7);
    rd(5'h06, d); chk("R9 shadow ovf", d, 1);
    rd(5'h05, d); chk("R9 shadow low hi", d, 0);
    wr(5'h00, 8'h00);

    // period 0: overflow counter advances every step
    wr(5'h02, 8'h00); wr(5'h03, 8'h00);
    wr(5'h00, 8'h02);
    ticks(3);
    rd(5'h04, d); chk("R3 period0 low", d, 0);
    rd(5'h06, d); chk("R3 period0 ovf", d, 3);
    rd(5'h02, d); chk("R10 period readback", d, 0);

    summary();
  end
endmodule